// File: doc/BRIEF.md
# Store Ordering Buffer With Fence

This block is a per-thread store buffer that sits between a core and the memory system. Each store enters with a class bit. A strict store becomes visible in program order with respect to every older store of the thread. A relaxed store, which is a streaming store, may complete after younger stores. Because it does not wait for older stores to be acknowledged, it reaches memory sooner.

Stores are presented to memory one at a time, in the order they were accepted. Memory acknowledges each store by its entry tag after a variable delay, and the acknowledgements may come back in any order. An entry is released when its acknowledgement arrives. A fence request blocks new stores until every outstanding store of both classes has been acknowledged. The block then returns a one-cycle done pulse. The buffer holds eight stores by default. It refuses new stores when full and never loses or repeats one.

Top module: `store_order_buf`

## Requirements
- R1: After reset, enq_ready is 1, mem_req_valid is 0 and fence_done is 0.
- R2: Every accepted store is presented on the memory port exactly once, in acceptance order, with its own address and data. Tags are handed out in acceptance order as 0, 1, ..., DEPTH-1 and then wrap back to 0.
- R3: A strict store (enq_relaxed = 0) is presented only after every older store of either class has been acknowledged. It is presented at the earliest in the cycle after the last such acknowledgement.
- R4: A relaxed store (enq_relaxed = 1) does not wait for older acknowledgements. When no older store is still unpresented, it is presented in the cycle after it is accepted.
- R5: Acknowledgements may arrive in any order, and a younger store may complete before an older one. An acknowledgement of a relaxed store does not release a strict store that is waiting for a different, older store.
- R6: While mem_req_valid is 1 and mem_req_ready is 0, the next cycle still shows mem_req_valid with the same tag.
- R7: With DEPTH stores accepted and none acknowledged, enq_ready is 0 and no further store is accepted.
- R8: From the cycle after a fence request until the done pulse, enq_ready is 0.
- R9: fence_done is high for exactly one cycle. Call C the later of two cycles: the cycle of the fence request and the cycle of the acknowledgement that leaves no store outstanding. fence_done is high two cycles after C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Store offered by the core |
| enq_ready | output | 1 | Buffer accepts a store this cycle |
| enq_relaxed | input | 1 | Store class: 0 strict, 1 relaxed |
| enq_addr | input | ADDR_W | Store address |
| enq_data | input | DATA_W | Store data |
| mem_req_valid | output | 1 | Store presented to memory |
| mem_req_ready | input | 1 | Memory takes the presented store |
| mem_req_tag | output | log2(DEPTH) | Entry tag of the presented store |
| mem_req_addr | output | ADDR_W | Address of the presented store |
| mem_req_data | output | DATA_W | Data of the presented store |
| mem_ack_valid | input | 1 | Completion from memory |
| mem_ack_tag | input | log2(DEPTH) | Tag of the completed store |
| fence_req | input | 1 | One-cycle fence request |
| fence_done | output | 1 | One-cycle pulse when the fence has drained |

## Verification
Each timed result has a fixed due cycle:
- A store accepted at one edge can be presented in the very next cycle.
- A strict store blocked by an older store can be presented in the cycle after that older store's acknowledgement.
- fence_done arrives two cycles after the later of the request and the final acknowledgement.

The bench drives every input on the falling edge and counts cycles on the rising edge. It compares each presentation, stall and done pulse against the cycle it predicts from these rules. Directed cases cover out-of-order completion, a fence with stores in flight, a fence on an empty buffer, and a full buffer. A long sweep then mixes classes, stalls, completion orders and fences. In the sweep, each presentation is checked against the bench's own record of which older stores are still unacknowledged.

// File: rtl/sob_pkg.sv
package sob_pkg;

    typedef enum logic {
        CLS_STRICT  = 1'b0,
        CLS_RELAXED = 1'b1
    } store_cls_e;

    typedef enum logic {
        FEN_IDLE = 1'b0,
        FEN_WAIT = 1'b1
    } fence_st_e;

endpackage

// File: rtl/sob_valid_track.sv
module sob_valid_track #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [DEPTH-1:0] valid_o,
    output logic             empty_o
);

    logic [DEPTH-1:0] live_d, live_q;

    always_comb begin
        live_d = live_q;
        if (clr_en) begin
            live_d[clr_idx] = 1'b0;
        end
        if (set_en) begin
            live_d[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    assign valid_o = live_q;
    assign empty_o = ~|live_q;

    // R2
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !live_q[set_idx]);

    // R5
    ack_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> live_q[clr_idx]);

endmodule

// File: rtl/sob_ring.sv
module sob_ring #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DEPTH-1:0] valid_i,
    output logic [PW-1:0]    head_o,
    output logic [PW-1:0]    tail_o,
    output logic             full_o
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [PW-1:0] occ;

    always_comb begin
        logic          stop;
        logic [PW-1:0] skip;
        logic [PW-1:0] pos;
        stop   = 1'b0;
        skip   = '0;
        pos    = '0;
        occ    = ring_q.tail - ring_q.head;
        ring_d = ring_q;
        for (int i = 0; i < DEPTH; i++) begin
            pos = ring_q.head + PW'(i);
            if (!stop && (PW'(i) < occ) && !valid_i[pos[IDX_W-1:0]]) begin
                skip = skip + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
        ring_d.head = ring_q.head + skip;
        ring_d.tail = ring_q.tail + PW'(push_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign head_o = ring_q.head;
    assign tail_o = ring_q.tail;
    assign full_o = (occ == PW'(DEPTH));

endmodule

// File: rtl/sob_issue.sv
module sob_issue #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    head_i,
    input  logic [PW-1:0]    tail_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic             cand_relaxed_i,
    input  logic             req_ready_i,
    output logic             req_valid_o,
    output logic [PW-1:0]    iss_ptr_o
);

    import sob_pkg::*;

    logic [PW-1:0] iss_d, iss_q;
    logic          older_busy;
    logic          has_cand;

    always_comb begin
        logic [PW-1:0] span;
        logic [PW-1:0] pos;
        span       = iss_q - head_i;
        pos        = '0;
        older_busy = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = head_i + PW'(i);
            if ((PW'(i) < span) && valid_i[pos[IDX_W-1:0]]) begin
                older_busy = 1'b1;
            end
        end
        has_cand    = (iss_q != tail_i);
        req_valid_o = has_cand &&
                      ((store_cls_e'(cand_relaxed_i) == CLS_RELAXED) || !older_busy);
        iss_d       = iss_q + PW'(req_valid_o && req_ready_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign iss_ptr_o = iss_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(iss_q)));

endmodule

// File: rtl/sob_fence.sv
module sob_fence (
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req_i,
    input  logic empty_i,
    output logic block_o,
    output logic done_o
);

    import sob_pkg::*;

    typedef struct packed {
        fence_st_e st;
        logic      done;
    } fen_t;

    fen_t fen_d, fen_q;

    always_comb begin
        fen_d      = fen_q;
        fen_d.done = 1'b0;
        case (fen_q.st)
            FEN_IDLE: begin
                if (fence_req_i) begin
                    fen_d.st = FEN_WAIT;
                end
            end
            FEN_WAIT: begin
                if (empty_i) begin
                    fen_d.st   = FEN_IDLE;
                    fen_d.done = 1'b1;
                end
            end
            default: fen_d.st = FEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fen_q <= '{st: FEN_IDLE, done: 1'b0};
        end else begin
            fen_q <= fen_d;
        end
    end

    assign block_o = (fen_q.st == FEN_WAIT);
    assign done_o  = fen_q.done;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> empty_i);

endmodule

// File: rtl/store_order_buf.sv
module store_order_buf #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic              enq_relaxed,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [IDX_W-1:0]  mem_req_tag,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_ack_valid,
    input  logic [IDX_W-1:0]  mem_ack_tag,
    input  logic              fence_req,
    output logic              fence_done
);

    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  rel_d, rel_q;

    logic [DEPTH-1:0] valid_vec;
    logic             buf_empty;
    logic [PW-1:0]    head_ptr, tail_ptr, iss_ptr;
    logic             buf_full;
    logic             fence_block;
    logic             push;
    logic [IDX_W-1:0] tail_idx, iss_idx;

    assign tail_idx  = tail_ptr[IDX_W-1:0];
    assign iss_idx   = iss_ptr[IDX_W-1:0];
    assign enq_ready = !buf_full && !fence_block;
    assign push      = enq_valid && enq_ready;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        rel_d  = rel_q;
        if (push) begin
            addr_d[tail_idx] = enq_addr;
            data_d[tail_idx] = enq_data;
            rel_d[tail_idx]  = enq_relaxed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '{default: '0};
            data_q <= '{default: '0};
            rel_q  <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
            rel_q  <= rel_d;
        end
    end

    sob_valid_track #(.DEPTH(DEPTH)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (push),
        .set_idx (tail_idx),
        .clr_en  (mem_ack_valid),
        .clr_idx (mem_ack_tag),
        .valid_o (valid_vec),
        .empty_o (buf_empty)
    );

    sob_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .valid_i (valid_vec),
        .head_o  (head_ptr),
        .tail_o  (tail_ptr),
        .full_o  (buf_full)
    );

    sob_issue #(.DEPTH(DEPTH)) u_issue (
        .clk            (clk),
        .rst_n          (rst_n),
        .head_i         (head_ptr),
        .tail_i         (tail_ptr),
        .valid_i        (valid_vec),
        .cand_relaxed_i (rel_q[iss_idx]),
        .req_ready_i    (mem_req_ready),
        .req_valid_o    (mem_req_valid),
        .iss_ptr_o      (iss_ptr)
    );

    sob_fence u_fence (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_req_i (fence_req),
        .empty_i     (buf_empty),
        .block_o     (fence_block),
        .done_o      (fence_done)
    );

    assign mem_req_tag  = iss_idx;
    assign mem_req_addr = addr_q[iss_idx];
    assign mem_req_data = data_q[iss_idx];

    // R2
    iss_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(iss_ptr - head_ptr) <= PW'(tail_ptr - head_ptr)));

    // R7
    full_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> !push);

endmodule

// File: tb/store_order_buf_bench.sv
module store_order_buf_bench;

    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 64;
    localparam int IW    = $clog2(DEPTH);
    localparam int MAXS  = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic          enq_ready;
    logic          enq_relaxed = 1'b0;
    logic [AW-1:0] enq_addr = '0;
    logic [DW-1:0] enq_data = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [IW-1:0] mem_req_tag;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic          mem_ack_valid = 1'b0;
    logic [IW-1:0] mem_ack_tag = '0;
    logic          fence_req = 1'b0;
    logic          fence_done;

    store_order_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_store_order_buf (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_relaxed(enq_relaxed),
        .enq_addr(enq_addr), .enq_data(enq_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_tag(mem_req_tag), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_ack_valid(mem_ack_valid), .mem_ack_tag(mem_ack_tag),
        .fence_req(fence_req), .fence_done(fence_done)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    logic [AW-1:0] e_addr [MAXS];
    logic [DW-1:0] e_data [MAXS];
    bit            e_rel  [MAXS];
    bit            e_ack  [MAXS];
    int            e_cyc  [MAXS];
    int            i_cyc  [MAXS];
    int n_enq = 0, n_iss = 0, oldest = 0;
    bit tag_out [DEPTH];
    int tag_seq [DEPTH];
    int mode_ready = 0, mode_ack = 0;
    bit man_pend = 0;
    int man_tag = 0;
    int last_ack_cyc = 0;
    bit fence_open = 0;
    int fence_cyc = 0;
    int n_done = 0;
    bit hold_prev = 0;
    int hold_tag = 0;
    logic [31:0] rng = 32'h1234_5678;

    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // memory model and monitor
    always @(negedge clk) begin
        bit nr;
        bit new_iss;
        int s;
        bit av;
        int at;
        if (rst_n && !ended) begin
            // fence tracking, R8 and R9
            if (fence_done) begin
                n_done++;
                if (fence_open) begin
                    chk(cyc == max2(fence_cyc, last_ack_cyc) + 2, "R9 done cycle",
                        cyc, max2(fence_cyc, last_ack_cyc) + 2);
                    chk(oldest == n_enq, "R9 all stores acknowledged", oldest, n_enq);
                    fence_open = 0;
                end else begin
                    chk(0, "R9 unexpected fence_done", 1, 0);
                end
            end else if (fence_open && cyc > fence_cyc) begin
                chk(enq_ready == 1'b0, "R8 enq_ready during fence", enq_ready, 0);
                if (oldest == n_enq && cyc > max2(fence_cyc, last_ack_cyc) + 2)
                    chk(0, "R9 fence_done late", 0, 1);
            end
            // R6 hold under stall
            if (hold_prev) begin
                chk(mem_req_valid == 1'b1, "R6 valid held", mem_req_valid, 1);
                chk(int'(mem_req_tag) == hold_tag, "R6 tag held", mem_req_tag, hold_tag);
            end
            // ready choice
            rng = nxt(rng);
            case (mode_ready)
                0: nr = 1'b0;
                1: nr = 1'b1;
                default: nr = (rng[1:0] != 2'b00);
            endcase
            hold_prev = mem_req_valid && !nr;
            hold_tag  = int'(mem_req_tag);
            // presentation checks, R2 and R3
            new_iss = 0;
            s = n_iss;
            if (mem_req_valid && nr) begin
                new_iss = 1;
                if (s >= n_enq) begin
                    chk(0, "R2 extra store presented", s, n_enq);
                end else begin
                    chk(int'(mem_req_tag) == s % DEPTH, "R2 tag", mem_req_tag, s % DEPTH);
                    chk(mem_req_addr == e_addr[s], "R2 address", mem_req_addr, e_addr[s]);
                    chk(mem_req_data == e_data[s], "R2 data", mem_req_data, e_data[s]);
                    if (!e_rel[s])
                        chk(oldest == s, "R3 strict store waits for older acks", oldest, s);
                end
                i_cyc[s] = cyc;
            end
            // acknowledgement choice, R5
            av = 0;
            at = 0;
            if (mode_ack == 1 && man_pend) begin
                av = 1;
                at = man_tag;
                man_pend = 0;
            end else if (mode_ack == 2 && rng[4:3] != 2'b00) begin
                for (int k = 0; k < DEPTH; k++) begin
                    int t;
                    t = (int'(rng[10:8]) + k) % DEPTH;
                    if (!av && tag_out[t]) begin
                        av = 1;
                        at = t;
                    end
                end
            end
            if (av) begin
                tag_out[at] = 0;
                e_ack[tag_seq[at]] = 1;
                while (oldest < n_enq && e_ack[oldest]) oldest++;
                last_ack_cyc = cyc;
            end
            if (new_iss) begin
                tag_out[s % DEPTH] = 1;
                tag_seq[s % DEPTH] = s;
                n_iss++;
            end
            mem_req_ready = nr;
            mem_ack_valid = av;
            mem_ack_tag   = IW'(at);
        end
    end

    task automatic enq(bit rel, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        while (!enq_ready) @(negedge clk);
        enq_valid   = 1'b1;
        enq_relaxed = rel;
        enq_addr    = a;
        enq_data    = d;
        e_addr[n_enq] = a;
        e_data[n_enq] = d;
        e_rel[n_enq]  = rel;
        e_ack[n_enq]  = 0;
        e_cyc[n_enq]  = cyc;
        n_enq++;
        @(posedge clk);
        #1 enq_valid = 1'b0;
    endtask

    task automatic fence();
        @(negedge clk);
        fence_req  = 1'b1;
        fence_cyc  = cyc;
        fence_open = 1;
        @(posedge clk);
        #1 fence_req = 1'b0;
    endtask

    task automatic ack_tag(int t);
        @(negedge clk);
        man_tag  = t;
        man_pend = 1;
        while (man_pend) @(negedge clk);
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int ack0;
        int base;
        for (int t = 0; t < DEPTH; t++) begin
            tag_out[t] = 0;
            tag_seq[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(enq_ready == 1'b1, "R1 enq_ready", enq_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
        chk(fence_done == 1'b0, "R1 fence_done", fence_done, 0);

        // directed: strict blocks, relaxed overtakes, out-of-order completion
        mode_ready = 1;
        mode_ack   = 1;
        enq(0, 32'h100, 64'hA0);   // seq0 strict
        enq(1, 32'h104, 64'hB1);   // seq1 relaxed
        enq(0, 32'h108, 64'hC2);   // seq2 strict
        enq(1, 32'h10C, 64'hD3);   // seq3 relaxed, in order behind seq2
        waitn(4);
        chk(n_iss == 2, "R3 strict store held behind unacked store", n_iss, 2);
        chk(i_cyc[1] == e_cyc[1] + 1, "R4 relaxed presented next cycle", i_cyc[1], e_cyc[1] + 1);
        ack_tag(1);                // younger completes first
        waitn(3);
        chk(n_iss == 2, "R5 younger ack does not release strict store", n_iss, 2);
        ack_tag(0);
        ack0 = last_ack_cyc;
        waitn(3);
        chk(n_iss == 4, "R2 remaining stores presented", n_iss, 4);
        chk(i_cyc[2] == ack0 + 1, "R3 strict store presented after last older ack", i_cyc[2], ack0 + 1);
        ack_tag(3);
        ack_tag(2);
        waitn(2);

        // directed: fence with stores outstanding
        enq(0, 32'h200, 64'hE4);   // seq4
        enq(1, 32'h204, 64'hF5);   // seq5
        waitn(3);
        fence();
        waitn(4);
        chk(n_done == 0, "R9 no done while stores outstanding", n_done, 0);
        ack_tag(5);
        ack_tag(4);
        waitn(5);
        chk(n_done == 1, "R9 fence done after drain", n_done, 1);
        chk(enq_ready == 1'b1, "R8 enq_ready back after fence", enq_ready, 1);

        // directed: fence on empty buffer
        fence();
        waitn(4);
        chk(n_done == 2, "R9 fence on empty buffer", n_done, 2);

        // directed: full buffer
        mode_ready = 0;
        mode_ack   = 0;
        waitn(2);
        base = n_enq;
        for (int k = 0; k < DEPTH; k++) enq(k[0], 32'h300 + 32'(k * 8), 64'(k * 3 + 1));
        waitn(2);
        chk(enq_ready == 1'b0, "R7 enq_ready low when full", enq_ready, 0);
        chk(n_enq - base == DEPTH, "R7 accepted count", n_enq - base, DEPTH);
        enq_valid = 1'b1;
        enq_addr  = 32'hDEAD;
        enq_data  = 64'hBEEF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(enq_ready == 1'b0, "R7 no accept while full", enq_ready, 0);
        end
        enq_valid = 1'b0;
        mode_ready = 2;
        mode_ack   = 2;
        fence();
        while (fence_open) @(negedge clk);

        // sweep: mixed classes, stalls, completion orders, fences
        for (int k = 0; k < 1200; k++) begin
            logic [31:0] r;
            rng = nxt(rng);
            r = rng;
            enq(r[0], {r[31:8], 8'h00}, {r, ~r});
            if (r[7:2] == 6'd5) begin
                fence();
                while (fence_open) @(negedge clk);
            end
        end
        fence();
        while (fence_open) @(negedge clk);
        waitn(2);
        chk(n_iss == n_enq, "R2 every store presented once", n_iss, n_enq);
        chk(oldest == n_enq, "R5 every store completed", oldest, n_enq);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule